// File: doc/BRIEF.md
# Lock Monitor with Reference Fallback

This block watches the sampled receive stream of a clock-recovery path and decides which source the recovery loop should follow: the incoming data or the local reference clock. It runs in the reference clock domain and takes one retimed data sample per cycle. It also takes a signal-present flag, a signed frequency-offset count, and a force-reference control. The offset count is the data-clock count minus the reference-clock count over a fixed measurement window, and it is qualified by a valid strobe.

Lock is lost when the data stays at one level for too long, or when the measured offset is larger than 244 ppm of the measurement window. On loss, the block selects the reference so that the downstream clock keeps its frequency. It waits a programmable number of cycles and then tries the data again. It repeats this until the data passes, so a stream that is present and has transitions but is off-frequency makes the status output toggle with every switch. A slip or phase jump in the stream is not a loss condition. Without a signal, or while the reference is forced, the block stays on the reference and does not retry.

The offset threshold is `OFF_LIMIT = floor(FREQ_WIN * 244 / 1e6)` counts. With the default window of 65536 it is 15.

Top module: `lock_fallback_ctrl`

## Requirements
- R1: While reset is active and on the first cycle after it, `sel_ref` is 1 and `lock_ok` is 0.
- R2: If the block is on the reference with no retry pending, and `sig_present` is 1 and `force_ref` is 0 at a clock edge, `lock_ok` is 1 after that edge. This is one cycle, well inside 2.5 us.
- R3: While following data, a run of `RUN_LIMIT` identical `rx_bit` samples keeps lock. The `RUN_LIMIT+1`-th identical sample makes `sel_ref` 1 after the edge that samples it. `RUN_LIMIT` must lie in 80..160.
- R4: While following data, a `freq_valid` strobe with |`freq_delta`| > `OFF_LIMIT` causes loss after that edge. `freq_delta` is two's complement. A magnitude equal to `OFF_LIMIT` keeps lock, and `freq_delta` is ignored while `freq_valid` is 0.
- R5: After a loss, with the signal present and the reference not forced, `sel_ref` stays 1 for exactly max(`dwell_cycles`,1) cycles. The block then follows data again.
- R6: If every data attempt fails on frequency, the source alternates between reference and data. With a measurement on every cycle, `lock_ok` repeats the pattern 0 for max(`dwell_cycles`,1) cycles, then 1 for one cycle.
- R7: When `sig_present` is 0, the next cycle shows `lock_ok` = 0. `lock_ok` then stays 0 with no retry until the signal returns.
- R8: When `force_ref` is 1, the next cycle shows `sel_ref` = 1 and `lock_ok` = 0, whatever the data does.
- R9: Sample slips (isolated repeated samples) in an otherwise transitioning stream never cause loss while runs stay within `RUN_LIMIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Retimed data sample, one per cycle |
| sig_present | input | 1 | Input signal above the detection threshold |
| freq_valid | input | 1 | Strobe qualifying `freq_delta` |
| freq_delta | input | DELTA_W | Signed window count difference (data minus reference) |
| force_ref | input | 1 | Forces the reference source |
| dwell_cycles | input | DWELL_W | Reference dwell length before each retry (0 acts as 1) |
| sel_ref | output | 1 | 1: loop follows reference, 0: loop follows data |
| lock_ok | output | 1 | Status: 1 while following data |

## Verification
The hardest state to reach from the ports is the endless alternation of R6. It needs a stream that is present, has transitions, and still fails every attempt. The bench keeps the data toggling and holds a bad offset strobe on every cycle. It then compares each cycle of `lock_ok` against the arithmetic period max(`dwell_cycles`,1)+1. The exact run-length edge of R3 is reached by holding `rx_bit` from a known transition and counting samples one by one. The offset threshold is swept over every value from -20 to +20 around the derived limit.

// File: rtl/lkf_pkg.sv
package lkf_pkg;
   typedef enum logic [1:0] {
      ST_REF_IDLE  = 2'd0,
      ST_DATA      = 2'd1,
      ST_REF_DWELL = 2'd2
   } lkf_state_e;

   localparam int unsigned PPM_SCALE = 1_000_000;
endpackage

// File: rtl/lkf_run_monitor.sv
module lkf_run_monitor #(
   parameter int unsigned RUN_LIMIT = 120
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic rx_bit,
   output logic run_viol
);
   localparam int unsigned CW = $clog2(RUN_LIMIT + 1);

   logic          prev_q;
   logic [CW-1:0] eq_q;
   logic          same;

   initial begin : p_param_chk
      if (RUN_LIMIT < 80 || RUN_LIMIT > 160)
         $fatal(1, "RUN_LIMIT outside 80..160");
   end

   assign same     = (rx_bit == prev_q);
   assign run_viol = arm && same && (eq_q >= CW'(RUN_LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         eq_q   <= '0;
      end else begin
         prev_q <= rx_bit;
         if (!arm || !same)
            eq_q <= '0;
         else if (eq_q < CW'(RUN_LIMIT))
            eq_q <= eq_q + CW'(1);
      end
   end

   AST_RUN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      arm |-> (eq_q < CW'(RUN_LIMIT))); // R3
endmodule

// File: rtl/lkf_freq_screen.sv
module lkf_freq_screen #(
   parameter int unsigned DELTA_W    = 16,
   parameter int unsigned FREQ_WIN   = 65536,
   parameter int unsigned PPM_LIMIT  = 244,
   parameter bit          FREQ_CHECK = 1'b1
) (
   input  logic               freq_valid,
   input  logic [DELTA_W-1:0] freq_delta,
   output logic               freq_bad
);
   localparam longint unsigned OFF_LIMIT =
      (longint'(FREQ_WIN) * longint'(PPM_LIMIT)) / longint'(lkf_pkg::PPM_SCALE);

   initial begin : p_param_chk
      if (DELTA_W < 2 || DELTA_W > 31)
         $fatal(1, "DELTA_W outside 2..31");
      if (OFF_LIMIT >= (64'd1 << (DELTA_W - 1)))
         $fatal(1, "offset limit not representable in DELTA_W");
   end

   generate
      if (FREQ_CHECK) begin : g_check
         logic [DELTA_W:0] mag;
         always_comb begin
            if (freq_delta[DELTA_W-1])
               mag = {1'b0, ~freq_delta} + (DELTA_W+1)'(1);
            else
               mag = {1'b0, freq_delta};
         end
         assign freq_bad = freq_valid && (mag > (DELTA_W+1)'(OFF_LIMIT));
      end else begin : g_bypass
         assign freq_bad = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/lkf_dwell_timer.sv
module lkf_dwell_timer #(
   parameter int unsigned DWELL_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               active,
   input  logic [DWELL_W-1:0] dwell_cycles,
   output logic               done
);
   logic [DWELL_W-1:0] cnt_q;
   logic [DWELL_W-1:0] eff;
   logic [DWELL_W:0]   nxt;

   initial begin : p_param_chk
      if (DWELL_W < 1 || DWELL_W > 24)
         $fatal(1, "DWELL_W outside 1..24");
   end

   assign eff  = (dwell_cycles == '0) ? DWELL_W'(1) : dwell_cycles;
   assign nxt  = {1'b0, cnt_q} + (DWELL_W+1)'(1);
   assign done = active && (nxt >= {1'b0, eff});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!active || done)
         cnt_q <= '0;
      else
         cnt_q <= nxt[DWELL_W-1:0];
   end

   AST_DWELL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !active); // R5
endmodule

// File: rtl/lock_fallback_ctrl.sv
module lock_fallback_ctrl #(
   parameter int unsigned RUN_LIMIT  = 120,
   parameter int unsigned FREQ_WIN   = 65536,
   parameter int unsigned PPM_LIMIT  = 244,
   parameter int unsigned DELTA_W    = 16,
   parameter int unsigned DWELL_W    = 12,
   parameter bit          FREQ_CHECK = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_bit,
   input  logic               sig_present,
   input  logic               freq_valid,
   input  logic [DELTA_W-1:0] freq_delta,
   input  logic               force_ref,
   input  logic [DWELL_W-1:0] dwell_cycles,
   output logic               sel_ref,
   output logic               lock_ok
);
   import lkf_pkg::*;

   lkf_state_e state_q, state_d;
   logic       run_viol;
   logic       freq_bad;
   logic       dwell_done;
   logic       in_data;
   logic       in_dwell;
   logic       can_try;

   assign in_data  = (state_q == ST_DATA);
   assign in_dwell = (state_q == ST_REF_DWELL);
   assign can_try  = sig_present && !force_ref;

   lkf_run_monitor #(.RUN_LIMIT(RUN_LIMIT)) u_run (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (in_data),
      .rx_bit   (rx_bit),
      .run_viol (run_viol)
   );

   lkf_freq_screen #(
      .DELTA_W    (DELTA_W),
      .FREQ_WIN   (FREQ_WIN),
      .PPM_LIMIT  (PPM_LIMIT),
      .FREQ_CHECK (FREQ_CHECK)
   ) u_freq (
      .freq_valid (freq_valid),
      .freq_delta (freq_delta),
      .freq_bad   (freq_bad)
   );

   lkf_dwell_timer #(.DWELL_W(DWELL_W)) u_dwell (
      .clk          (clk),
      .rst_n        (rst_n),
      .active       (in_dwell),
      .dwell_cycles (dwell_cycles),
      .done         (dwell_done)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_REF_IDLE: begin
            if (can_try) state_d = ST_DATA;
         end
         ST_DATA: begin
            if (!can_try)                  state_d = ST_REF_IDLE;
            else if (run_viol || freq_bad) state_d = ST_REF_DWELL;
         end
         ST_REF_DWELL: begin
            if (!can_try)        state_d = ST_REF_IDLE;
            else if (dwell_done) state_d = ST_DATA;
         end
         default: state_d = ST_REF_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_REF_IDLE;
      else        state_q <= state_d;
   end

   assign lock_ok = in_data;
   assign sel_ref = !in_data;

   AST_FORCE_REF: assert property (@(posedge clk) disable iff (!rst_n)
      force_ref |=> (sel_ref && !lock_ok)); // R8
   AST_NOSIG_REF: assert property (@(posedge clk) disable iff (!rst_n)
      !sig_present |=> !lock_ok); // R7
   AST_RUN_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_ok && run_viol) |=> sel_ref); // R3
   AST_FREQ_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_ok && freq_bad) |=> !lock_ok); // R4
   AST_FAST_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sig_present) && !force_ref) |=> lock_ok); // R2
endmodule

// File: tb/tb_lock_fallback_ctrl.sv
`timescale 1ns/1ps
module tb_lock_fallback_ctrl;
   localparam int RUN_LIMIT = 80;
   localparam int DELTA_W   = 8;
   localparam int DWELL_W   = 4;
   localparam int OFF_LIM   = (65536 * 244) / 1000000; // 15

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               rx_bit = 1'b0;
   logic               sig_present = 1'b0;
   logic               freq_valid = 1'b0;
   logic [DELTA_W-1:0] freq_delta = '0;
   logic               force_ref = 1'b0;
   logic [DWELL_W-1:0] dwell_cycles = 4'd3;
   logic               sel_ref, lock_ok;
   logic               tog = 1'b1;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   lock_fallback_ctrl #(
      .RUN_LIMIT(RUN_LIMIT), .FREQ_WIN(65536), .PPM_LIMIT(244),
      .DELTA_W(DELTA_W), .DWELL_W(DWELL_W), .FREQ_CHECK(1'b1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .sig_present(sig_present),
      .freq_valid(freq_valid), .freq_delta(freq_delta), .force_ref(force_ref),
      .dwell_cycles(dwell_cycles), .sel_ref(sel_ref), .lock_ok(lock_ok)
   );

   task automatic cyc();
      @(negedge clk);
      if (tog) rx_bit = ~rx_bit;
   endtask

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_lock();
      for (int i = 0; i < 40 && !lock_ok; i++) cyc();
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      int errs;
      int cnt;
      // R1: reset state
      repeat (3) cyc();
      check("R1 sel_ref in reset", sel_ref, 1);
      check("R1 lock_ok in reset", lock_ok, 0);
      rst_n = 1'b1;
      cyc();
      check("R1 after reset", {sel_ref, lock_ok}, 2'b10);

      // R7: no signal, no retry
      errs = 0;
      for (int i = 0; i < 20; i++) begin cyc(); if (lock_ok) errs++; end
      check("R7 idle without signal", errs, 0);

      // R2: fast acquisition
      sig_present = 1'b1;
      cyc();
      check("R2 lock one cycle after signal", lock_ok, 1);

      // R9: sample slips keep lock
      errs = 0;
      for (int i = 0; i < 210; i++) begin
         tog = (i % 7 != 3);
         cyc();
         if (!lock_ok) errs++;
      end
      tog = 1'b1;
      cyc();
      check("R9 phase slips no loss", errs, 0);

      // R3: exact run-length boundary
      cyc();
      tog = 1'b0;
      for (int j = 1; j <= RUN_LIMIT; j++) cyc();
      check("R3 run of RUN_LIMIT keeps lock", lock_ok, 1);
      cyc();
      check("R3 run of RUN_LIMIT+1 loses lock", sel_ref, 1);
      tog = 1'b1;

      // R5: dwell length sweep
      for (int d = 0; d < 8; d++) begin
         wait_lock();
         dwell_cycles = DWELL_W'(d);
         freq_delta = 8'd40;
         freq_valid = 1'b1;
         cyc();
         freq_valid = 1'b0;
         cnt = 0;
         while (sel_ref && cnt < 40) begin cnt++; cyc(); end
         check($sformatf("R5 dwell %0d", d), cnt, (d == 0) ? 1 : d);
      end

      // R4: offset threshold sweep
      dwell_cycles = 4'd2;
      for (int d = -20; d <= 20; d++) begin
         wait_lock();
         freq_delta = DELTA_W'(d);
         freq_valid = 1'b1;
         cyc();
         freq_valid = 1'b0;
         check($sformatf("R4 delta %0d", d), lock_ok,
               ((d > OFF_LIM) || (-d > OFF_LIM)) ? 0 : 1);
      end
      wait_lock();
      freq_delta = 8'd100;
      errs = 0;
      for (int i = 0; i < 10; i++) begin cyc(); if (!lock_ok) errs++; end
      check("R4 delta ignored without strobe", errs, 0);

      // R6: persistent off-frequency input alternates sources
      freq_delta = 8'hCE; // -50
      freq_valid = 1'b1;
      errs = 0;
      cnt = 0;
      for (int k = 1; k <= 30; k++) begin
         cyc();
         if (lock_ok != ((k % 3) == 0)) errs++;
         if (lock_ok) cnt++;
      end
      freq_valid = 1'b0;
      check("R6 toggle pattern", errs, 0);
      check("R6 data attempts", cnt, 10);

      // R8: forced reference
      wait_lock();
      force_ref = 1'b1;
      cyc();
      check("R8 force selects reference", {sel_ref, lock_ok}, 2'b10);
      errs = 0;
      for (int i = 0; i < 20; i++) begin cyc(); if (lock_ok || !sel_ref) errs++; end
      check("R8 force held", errs, 0);
      force_ref = 1'b0;
      cyc();
      check("R2 lock after force release", lock_ok, 1);

      // R7: signal loss, no retry beyond dwell
      sig_present = 1'b0;
      cyc();
      check("R7 signal loss", lock_ok, 0);
      errs = 0;
      for (int i = 0; i < 30; i++) begin cyc(); if (lock_ok) errs++; end
      check("R7 no retry without signal", errs, 0);
      sig_present = 1'b1;
      cyc();
      check("R2 lock on signal return", lock_ok, 1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule